// File: doc/BRIEF.md
# Serial Memory Status and Write-Protect Logic

This block is the device-side control of a small serial memory on a four-wire SPI link (mode 0). It frames each command with chip select and shifts in an 8-bit opcode, most significant bit first. It holds the 8-bit status register and answers the status-read opcode by shifting that byte back out. It keeps the write-enable latch. A status write starts a timed internal write cycle, and during that cycle the block reports busy and refuses every command except status read.

The two block-protect bits are decoded into a per-sector protect mask for the array logic. Each higher code protects a larger range that always includes the top sector. The serial pins are oversampled in the system clock domain, so SCLK must stay at least a few system clocks in each phase. The internal write cycle is counted in system clocks.

Top module: `spi_mem_status`

## Requirements
- R1: Opcode bits are sampled on rising SCLK while cs_n is low, MSB first. A command takes effect only when cs_n rises after exactly 8 bits (enable/disable write) or exactly 16 bits (status write). Any other count leaves all state unchanged.
- R2: After opcode 0x05, the status byte is driven on so, MSB first. It is updated on each falling SCLK that follows the 8th rising edge. so_oe is 1 only for those 8 bit periods and is 0 during the opcode, after the byte, on any other command and while cs_n is high.
- R3: Status byte layout: bit 7 write-protect-enable, bits 6..4 always 0, bits 3..2 block-protect code, bit 1 write-enable latch, bit 0 busy (1 while an internal write cycle runs, 0 when ready).
- R4: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it.
- R5: Opcode 0x01 followed by a data byte is accepted only when the write-enable latch is 1 and not both write-protect-enable is 1 and wp_n is 0. It stores data bit 7 as write-protect-enable and data bits 3..2 as the block-protect code. The other data bits are ignored.
- R6: An accepted status write raises wr_busy on the clock after cs_n rises and holds it for exactly WRITE_CYCLES clocks. When busy ends, the write-enable latch is cleared.
- R7: While wr_busy is 1, every opcode other than 0x05 is ignored. A status read still works and shows bit 0 as 1.
- R8: sect_protect bit i guards sector i (0..NUM_SECTORS-1). Code 00 protects none, 01 protects the top NUM_SECTORS/4 sectors, 10 the top half, and 11 all sectors.
- R9: After reset, the status byte is 0x00, wr_busy is 0, so_oe is 0 and sect_protect is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low; frames each command |
| sclk | input | 1 | Serial clock, mode 0 |
| mosi | input | 1 | Serial data from the host |
| wp_n | input | 1 | Hardware write-protect pin, active low |
| so | output | 1 | Serial data to the host; meaningful only when so_oe is 1 |
| so_oe | output | 1 | Output enable for so; 0 models high impedance |
| wr_busy | output | 1 | Internal write cycle in progress |
| sect_protect | output | NUM_SECTORS | Per-sector write-protect mask |

## Verification
The checker covers several rules on every cycle: the busy window length, clearing of the write-enable latch when busy ends, and the gate on starting a write. It also checks that protect state is frozen while busy, the shape of the sector mask against the stored code, and that so_oe stays low while deselected. The bit order and content of the shifted status byte, aborted frames of the wrong length, and the refusal of commands while busy can only be shown by the bench. Its scenarios drive full frames and compare each read-back byte with fixed values and with a behavioural model. The model also tracks wr_busy and the mask on every clock.

// File: rtl/spi_mem_status_pkg.sv
package spi_mem_status_pkg;

  localparam logic [7:0] OP_RD_STATUS = 8'h05;
  localparam logic [7:0] OP_WR_STATUS = 8'h01;
  localparam logic [7:0] OP_WR_ENABLE = 8'h06;
  localparam logic [7:0] OP_WR_DISABLE = 8'h04;

  localparam int CMD_BITS   = 8;
  localparam int FRAME_BITS = 16;

  // Status byte: [7] protect-enable, [6:4] zero, [3:2] block code, [1] enable latch, [0] busy
  function automatic logic [7:0] pack_status(input logic wpen, input logic [1:0] bp,
                                             input logic wen, input logic busy);
    pack_status = {wpen, 3'b000, bp, wen, busy};
  endfunction

  // Number of top sectors covered by a block-protect code
  function automatic int protect_span(input logic [1:0] bp, input int sectors);
    case (bp)
      2'b00:   protect_span = 0;
      2'b01:   protect_span = sectors / 4;
      2'b10:   protect_span = sectors / 2;
      default: protect_span = sectors;
    endcase
  endfunction

endpackage

// File: rtl/spi_mem_status_shifter.sv
module spi_mem_status_shifter
  import spi_mem_status_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sclk,
  input  logic       mosi,
  input  logic [7:0] status_in,
  output logic       so,
  output logic       so_oe,
  output logic       frame_end,
  output logic [4:0] frame_bits,
  output logic [7:0] opcode,
  output logic       wr_wpen,
  output logic [1:0] wr_bp
);

  localparam logic [4:0] CNT_SAT  = 5'(FRAME_BITS + 1);
  localparam logic [4:0] CNT_OP   = 5'(CMD_BITS);
  localparam logic [4:0] CNT_LAST = 5'(FRAME_BITS);

  logic       sclk_q, cs_q;
  logic [4:0] cnt_q;
  logic [7:0] rx_q, op_q, tx_q;
  logic       oe_q;
  logic       rise_ev, fall_ev;

  assign rise_ev   = !cs_n && sclk && !sclk_q;
  assign fall_ev   = !cs_n && !sclk && sclk_q;
  assign frame_end = cs_n && !cs_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
      cnt_q  <= '0;
      rx_q   <= '0;
      op_q   <= '0;
      tx_q   <= '0;
      oe_q   <= 1'b0;
    end else begin
      sclk_q <= sclk;
      cs_q   <= cs_n;
      if (cs_n) begin
        cnt_q <= '0;
        oe_q  <= 1'b0;
      end else begin
        if (rise_ev) begin
          rx_q <= {rx_q[6:0], mosi};
          if (cnt_q != CNT_SAT) cnt_q <= cnt_q + 5'd1;
          if (cnt_q == CNT_OP - 5'd1) op_q <= {rx_q[6:0], mosi};
        end
        if (fall_ev) begin
          if (cnt_q == CNT_OP && op_q == OP_RD_STATUS) begin
            tx_q <= status_in;
            oe_q <= 1'b1;
          end else if (cnt_q >= CNT_LAST) begin
            oe_q <= 1'b0;
          end else begin
            tx_q <= {tx_q[6:0], 1'b0};
          end
        end
      end
    end
  end

  assign so         = tx_q[7];
  assign so_oe      = oe_q;
  assign frame_bits = cnt_q;
  assign opcode     = op_q;
  assign wr_wpen    = rx_q[7];
  assign wr_bp      = rx_q[3:2];

endmodule

// File: rtl/spi_mem_status_regs.sv
module spi_mem_status_regs
  import spi_mem_status_pkg::*;
#(
  parameter int WRITE_CYCLES = 5000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_end,
  input  logic [4:0] frame_bits,
  input  logic [7:0] opcode,
  input  logic       wr_wpen,
  input  logic [1:0] wr_bp,
  input  logic       wp_n,
  output logic       wpen,
  output logic [1:0] bp,
  output logic       wen,
  output logic       busy,
  output logic       wrsr_go
);

  localparam int TMR_W = (WRITE_CYCLES > 2) ? $clog2(WRITE_CYCLES) : 1;
  localparam logic [TMR_W-1:0] TMR_LOAD = TMR_W'(WRITE_CYCLES - 1);

  logic [TMR_W-1:0] tmr_q;
  logic             len8, len16, hw_locked;

  assign len8      = frame_bits == 5'(CMD_BITS);
  assign len16     = frame_bits == 5'(FRAME_BITS);
  assign hw_locked = wpen && !wp_n;
  assign wrsr_go   = !busy && frame_end && len16 && opcode == OP_WR_STATUS && wen && !hw_locked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wpen  <= 1'b0;
      bp    <= 2'b00;
      wen   <= 1'b0;
      busy  <= 1'b0;
      tmr_q <= '0;
    end else if (busy) begin
      if (tmr_q == '0) begin
        busy <= 1'b0;
        wen  <= 1'b0;
      end else begin
        tmr_q <= tmr_q - 1'b1;
      end
    end else if (wrsr_go) begin
      wpen  <= wr_wpen;
      bp    <= wr_bp;
      busy  <= 1'b1;
      tmr_q <= TMR_LOAD;
    end else if (frame_end && len8) begin
      if (opcode == OP_WR_ENABLE) wen <= 1'b1;
      else if (opcode == OP_WR_DISABLE) wen <= 1'b0;
    end
  end

endmodule

// File: rtl/spi_mem_status_protect.sv
module spi_mem_status_protect
  import spi_mem_status_pkg::*;
#(
  parameter int NUM_SECTORS = 4
) (
  input  logic [1:0]             bp,
  output logic [NUM_SECTORS-1:0] mask
);

  int span;
  assign span = protect_span(bp, NUM_SECTORS);

  for (genvar i = 0; i < NUM_SECTORS; i++) begin : g_sect
    assign mask[i] = (i >= NUM_SECTORS - span);
  end

endmodule

// File: rtl/spi_mem_status.sv
module spi_mem_status
  import spi_mem_status_pkg::*;
#(
  parameter int NUM_SECTORS  = 4,
  parameter int WRITE_CYCLES = 5000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cs_n,
  input  logic                   sclk,
  input  logic                   mosi,
  input  logic                   wp_n,
  output logic                   so,
  output logic                   so_oe,
  output logic                   wr_busy,
  output logic [NUM_SECTORS-1:0] sect_protect
);

  logic       frame_end_w, wpen_w, wen_w, wrsr_go_w, wr_wpen_w;
  logic [4:0] frame_bits_w;
  logic [7:0] opcode_w, status_w;
  logic [1:0] bp_w, wr_bp_w;

  assign status_w = pack_status(wpen_w, bp_w, wen_w, wr_busy);

  spi_mem_status_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
    .status_in(status_w), .so(so), .so_oe(so_oe), .frame_end(frame_end_w),
    .frame_bits(frame_bits_w), .opcode(opcode_w), .wr_wpen(wr_wpen_w), .wr_bp(wr_bp_w)
  );

  spi_mem_status_regs #(.WRITE_CYCLES(WRITE_CYCLES)) u_regs (
    .clk(clk), .rst_n(rst_n), .frame_end(frame_end_w), .frame_bits(frame_bits_w),
    .opcode(opcode_w), .wr_wpen(wr_wpen_w), .wr_bp(wr_bp_w), .wp_n(wp_n),
    .wpen(wpen_w), .bp(bp_w), .wen(wen_w), .busy(wr_busy), .wrsr_go(wrsr_go_w)
  );

  spi_mem_status_protect #(.NUM_SECTORS(NUM_SECTORS)) u_prot (
    .bp(bp_w), .mask(sect_protect)
  );

endmodule

// File: rtl/spi_mem_status_chk.sv
module spi_mem_status_chk #(
  parameter int NUM_SECTORS  = 4,
  parameter int WRITE_CYCLES = 5000
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cs_n,
  input logic                   wp_n,
  input logic                   so_oe,
  input logic                   busy,
  input logic                   wen,
  input logic                   wpen,
  input logic [1:0]             bp,
  input logic                   wrsr_go,
  input logic [NUM_SECTORS-1:0] mask
);

  logic [31:0] run_q;
  always_ff @(posedge clk) begin
    if (!rst_n) run_q <= '0;
    else if (busy) run_q <= run_q + 32'd1;
    else run_q <= '0;
  end

  // R2
  oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n && $past(cs_n) |-> !so_oe);

  // R6
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> run_q == 32'(WRITE_CYCLES));

  // R6
  wen_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !wen);

  // R5
  wrsr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wen) && !($past(wpen) && !$past(wp_n)) && $past(wrsr_go));

  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(wen) && $stable(wpen) && $stable(bp));

  // R8
  mask_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bp == 2'b00 |-> mask == '0);

  // R8
  mask_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bp != 2'b00 |-> mask[NUM_SECTORS-1]);

  // R8
  mask_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bp == 2'b11 |-> &mask);

endmodule

bind spi_mem_status spi_mem_status_chk #(
  .NUM_SECTORS(NUM_SECTORS), .WRITE_CYCLES(WRITE_CYCLES)
) chk_i (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wp_n(wp_n), .so_oe(so_oe), .busy(wr_busy),
  .wen(wen_w), .wpen(wpen_w), .bp(bp_w), .wrsr_go(wrsr_go_w), .mask(sect_protect)
);

// File: tb/spi_mem_status_tb_top.sv
module spi_mem_status_tb_top;

  localparam int NS = 8;
  localparam int WC = 600;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0, wp_n = 1'b1;
  logic so, so_oe, wr_busy;
  logic [NS-1:0] sect_protect;

  int n_chk = 0, n_fail = 0;
  bit done = 0, running = 0;

  always #5 clk = ~clk;

  spi_mem_status #(.NUM_SECTORS(NS), .WRITE_CYCLES(WC)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .wp_n(wp_n),
    .so(so), .so_oe(so_oe), .wr_busy(wr_busy), .sect_protect(sect_protect)
  );

  // behavioural reference model
  bit       q[$];
  bit       m_wen, m_wpen, prev_cs;
  bit [1:0] m_bp;
  int       m_left;
  int       busy_run;

  function automatic logic [NS-1:0] exp_mask(input bit [1:0] b);
    int k;
    k = (b == 0) ? 0 : (b == 1) ? NS / 4 : (b == 2) ? NS / 2 : NS;
    exp_mask = '0;
    for (int i = 0; i < k; i++) exp_mask[NS-1-i] = 1'b1;
  endfunction

  function automatic logic [7:0] model_status();
    model_status = 8'h00;
    model_status[7] = m_wpen;
    model_status[3:2] = m_bp;
    model_status[1] = m_wen;
    model_status[0] = (m_left > 0);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_wen = 0; m_wpen = 0; m_bp = 0; m_left = 0; prev_cs = 1;
    end else begin
      if (m_left > 0) begin
        m_left--;
        if (m_left == 0) m_wen = 0;
      end else if (cs_n && !prev_cs) begin
        logic [7:0] op, d;
        op = 0; d = 0;
        for (int i = 0; i < 8 && i < q.size(); i++) op[7-i] = q[i];
        for (int i = 8; i < 16 && i < q.size(); i++) d[15-i] = q[i];
        if (q.size() == 8 && op == 8'h06) m_wen = 1;
        else if (q.size() == 8 && op == 8'h04) m_wen = 0;
        else if (q.size() == 16 && op == 8'h01 && m_wen && !(m_wpen && !wp_n)) begin
          m_wpen = d[7]; m_bp = d[3:2]; m_left = WC;
        end
      end
      prev_cs = cs_n;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // per-clock comparison with the model (R6, R8)
  always @(negedge clk) begin
    if (rst_n && running) begin
      check(wr_busy == (m_left > 0), "R6", "wr_busy vs model", wr_busy, m_left > 0);
      check(sect_protect == exp_mask(m_bp), "R8", "sect_protect vs model",
            sect_protect, exp_mask(m_bp));
      if (wr_busy) busy_run++;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  logic [7:0] exp_st;

  task automatic frame(input logic [15:0] v, input int nb, input bit is_rd,
                       output logic [7:0] got);
    @(negedge clk);
    q.delete();
    got = 0;
    cs_n = 0; sclk = 0;
    tick(4);
    for (int i = 0; i < nb; i++) begin
      mosi = v[15-i];
      tick(4);
      if (is_rd && i >= 8 && i < 16) begin
        check(so_oe == 1, "R2", "so_oe during status byte", so_oe, 1);
        got = {got[6:0], so};
      end else begin
        check(so_oe == 0, "R2", "so_oe outside status byte", so_oe, 0);
      end
      sclk = 1;
      q.push_back(mosi);
      tick(4);
      sclk = 0;
      if (is_rd && i == 7) exp_st = model_status();
    end
    tick(4);
    if (nb >= 16) check(so_oe == 0, "R2", "so_oe after byte", so_oe, 0);
    cs_n = 1;
    tick(6);
    check(so_oe == 0, "R2", "so_oe deselected", so_oe, 0);
  endtask

  task automatic rd_check(input logic [7:0] expv, input string req);
    logic [7:0] s;
    frame({8'h05, 8'h00}, 16, 1, s);
    check(s == expv, req, "status byte", s, expv);
    check(s == exp_st, "R3", "status byte vs model", s, exp_st);
  endtask

  task automatic cmd8(input logic [7:0] op);
    logic [7:0] s;
    frame({op, 8'h00}, 8, 0, s);
  endtask

  task automatic wrsr(input logic [7:0] d);
    logic [7:0] s;
    frame({8'h01, d}, 16, 0, s);
  endtask

  task automatic wait_idle();
    int guard = 0;
    while (wr_busy && guard < 5000) begin tick(1); guard++; end
    tick(2);
  endtask

  initial begin
    logic [7:0] s;
    tick(4);
    rst_n = 1;
    tick(2);
    running = 1;
    // R9 reset state
    check(wr_busy == 0, "R9", "wr_busy after reset", wr_busy, 0);
    check(so_oe == 0, "R9", "so_oe after reset", so_oe, 0);
    check(sect_protect == 0, "R9", "mask after reset", sect_protect, 0);
    rd_check(8'h00, "R9");

    // R5 status write refused without write enable
    wrsr(8'h8C);
    check(wr_busy == 0, "R5", "no busy without enable", wr_busy, 0);
    rd_check(8'h00, "R5");

    // R4 enable and disable latch
    cmd8(8'h06);
    rd_check(8'h02, "R4");
    cmd8(8'h04);
    rd_check(8'h00, "R4");

    // R1 wrong frame lengths abort
    frame({8'h06, 8'h00}, 5, 0, s);
    rd_check(8'h00, "R1");
    frame({8'h06, 8'h00}, 9, 0, s);
    rd_check(8'h00, "R1");
    cmd8(8'h06);
    rd_check(8'h02, "R4");
    frame({8'h01, 8'h84}, 12, 0, s);
    check(wr_busy == 0, "R1", "short status write", wr_busy, 0);
    rd_check(8'h02, "R1");

    // R5/R6 accepted status write, reserved and read-only data bits ignored
    busy_run = 0;
    wrsr(8'hF5);
    check(wr_busy == 1, "R6", "busy after status write", wr_busy, 1);
    rd_check(8'h87, "R7");
    check(sect_protect == 8'hC0, "R8", "mask code 01", sect_protect, 8'hC0);
    // R7 commands ignored while busy
    cmd8(8'h04);
    rd_check(8'h87, "R7");
    wrsr(8'h0C);
    wait_idle();
    check(busy_run == WC, "R6", "busy length", busy_run, WC);
    rd_check(8'h84, "R6");
    check(sect_protect == 8'hC0, "R7", "mask kept after busy", sect_protect, 8'hC0);

    // R5 hardware pin blocks writes while protect-enable is set
    wp_n = 0;
    cmd8(8'h06);
    wrsr(8'h00);
    check(wr_busy == 0, "R5", "pin lock", wr_busy, 0);
    rd_check(8'h86, "R5");
    wp_n = 1;
    wrsr(8'h08);
    wait_idle();
    rd_check(8'h08, "R5");
    check(sect_protect == 8'hF0, "R8", "mask code 10", sect_protect, 8'hF0);

    // R5 pin low but protect-enable clear: write accepted
    wp_n = 0;
    cmd8(8'h06);
    wrsr(8'h0C);
    rd_check(8'h0F, "R7");
    check(sect_protect == 8'hFF, "R8", "mask code 11", sect_protect, 8'hFF);
    wait_idle();
    rd_check(8'h0C, "R6");

    wp_n = 1;
    cmd8(8'h06);
    wrsr(8'h00);
    wait_idle();
    rd_check(8'h00, "R8");
    check(sect_protect == 8'h00, "R8", "mask code 00", sect_protect, 8'h00);

    // R2 aborted status read releases so
    frame({8'h05, 8'h00}, 12, 1, s);

    running = 0;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule